// File: doc/BRIEF.md
# Interrupt Acknowledge Arbiter

This block decides which interrupt source answers an interrupt acknowledge cycle. It holds eight source slots. Each internal slot has three programmed values: a 3-bit request level, a 4-bit arbitration number and an 8-bit vector. Slot 0 is the system-integration slot. It speaks for requests from off-chip. Its request level comes from the `ext_req_lvl` input, and it has its own arbitration number.

When the processor starts an acknowledge cycle, it pulses `iack_start` and presents the 3-bit priority being acknowledged. Every slot whose request level is nonzero and equal to that priority takes part in contention. The contender with the largest arbitration number wins.

- If an internal slot wins, its vector is returned and the cycle is terminated.
- If slot 0 wins, the acknowledge is passed to an external-bus handshake. The external device must answer within a programmable number of cycles.
- If there is no contender, the winner's arbitration number is zero, or the external device does not answer in time, the cycle ends with a bus error. Software treats that as a spurious interrupt.

Software must give the arbiter distinct arbitration numbers. If two contenders share a nonzero number, the block flags a configuration conflict and still gives a defined answer.

Top module: `iack_arbiter`

## Requirements
- R1: After reset, slot 0 has arbitration number 15, and slots 1 to 7 have arbitration number 0 and request level 0. The external timeout limit is 16 cycles.
- R2: A slot contends only when its request level is nonzero and equal to `iack_lvl`. For slot 0 the request level is `ext_req_lvl`.
- R3: When `iack_start` is accepted, the contender with the largest arbitration number wins. If the winner is an internal slot with a nonzero number, `resp_valid` is high for one cycle in the next cycle, and `resp_vec` carries that slot's vector.
- R4: If the winning contender's arbitration number is 0, `resp_berr` is high for one cycle in the next cycle and no vector is returned.
- R5: If no slot contends, `resp_berr` is high for one cycle in the next cycle.
- R6: If two or more contenders share the winning nonzero number, `arb_conflict` is high for one cycle in the next cycle, and the lowest-numbered of those slots wins.
- R7: If slot 0 wins with a nonzero number, `xbus_ack_req` rises in the next cycle with `xbus_ack_lvl` equal to the acknowledged priority. Both are held until a response arrives or the timeout expires.
- R8: If `xbus_resp_valid` is high in a cycle where `xbus_ack_req` is high, the next cycle has `resp_valid` high with `resp_vec` equal to `xbus_resp_vec`, and `xbus_ack_req` low.
- R9: If no response arrives, `xbus_ack_req` stays high for exactly the timeout limit L in cycles, and `resp_berr` is high for one cycle in the next cycle. A programmed limit of 0 acts as 1.
- R10: A pulse on `iack_start` while `xbus_ack_req` is high is ignored.
- R11: `resp_valid` and `resp_berr` are never high together, and each pulse lasts one cycle.
- R12: A write with `cfg_we` high updates one register, selected by `cfg_slot` and `cfg_fld`:
  - `cfg_fld` 0 selects the arbitration number, taken from data bits [3:0].
  - `cfg_fld` 1 selects the request level, taken from bits [2:0]. A level write to slot 0 is ignored.
  - `cfg_fld` 2 selects the vector, taken from bits [7:0].
  - `cfg_fld` 3 selects the shared timeout limit, taken from bits [7:0], whatever the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_slot | input | 3 | Slot being written |
| cfg_fld | input | 2 | Field select: 0 arbitration, 1 level, 2 vector, 3 timeout |
| cfg_wdata | input | 8 | Write data |
| ext_req_lvl | input | 3 | Level of the pending external request, 0 = none |
| iack_start | input | 1 | One-cycle start of an acknowledge cycle |
| iack_lvl | input | 3 | Priority being acknowledged |
| resp_valid | output | 1 | Vector returned, cycle terminated |
| resp_vec | output | 8 | Returned vector |
| resp_berr | output | 1 | Cycle ended by bus error (spurious) |
| arb_conflict | output | 1 | Duplicate nonzero arbitration number among contenders |
| xbus_ack_req | output | 1 | Acknowledge forwarded to the external bus |
| xbus_ack_lvl | output | 3 | Priority presented to the external bus |
| xbus_resp_valid | input | 1 | External device answers |
| xbus_resp_vec | input | 8 | Vector from the external device |

## Verification
A corrupted arbitration, level or vector register shows one cycle after the next acknowledge that reaches the slot. It appears as the wrong vector, a bus error where a vector was due, or a forwarded external acknowledge where none belonged.

A fault in the wait counter shows in the length of the `xbus_ack_req` window. It shows either as a bus error arriving a cycle early or late, or as a window that never closes.

A stuck sequencing state shows as `xbus_ack_req` held high or a new acknowledge being ignored. The bench checks `xbus_ack_req` and the outputs on every cycle of every external wait, so a shift of one cycle is reported.

// File: rtl/iack_pkg.sv
// Package: shared constants for the interrupt acknowledge arbiter.
// Assumes: field codes are part of the software-visible write interface.
package iack_pkg;
    localparam logic [1:0] FLD_ARB = 2'd0;
    localparam logic [1:0] FLD_LVL = 2'd1;
    localparam logic [1:0] FLD_VEC = 2'd2;
    localparam logic [1:0] FLD_TMO = 2'd3;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/iack_regs.sv
// Module: per-slot arbitration, level and vector registers plus the shared
// external timeout limit.
// Assumes: slot 0 is the system-integration slot. Its level comes from
// outside, so level writes to it are dropped. ARB_W, LVL_W and TMO_W are
// all no wider than DATA_W.
module iack_regs
    import iack_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int ARB_W   = 4,
    parameter int LVL_W   = 3,
    parameter int DATA_W  = 8,
    parameter int TMO_W   = 8,
    parameter int TMO_RST = 16,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [SLOT_W-1:0]                 cfg_slot,
    input  logic [1:0]                        cfg_fld,
    input  logic [DATA_W-1:0]                 cfg_wdata,
    output logic [N_SLOTS-1:0][ARB_W-1:0]     arb_q,
    output logic [N_SLOTS-1:0][LVL_W-1:0]     lvl_q,
    output logic [N_SLOTS-1:0][DATA_W-1:0]    vec_q,
    output logic [TMO_W-1:0]                  tmo_q
);

    // Shared timeout limit register; the slot index is ignored for this field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo_q <= TMO_W'(TMO_RST);
        else if (cfg_we && cfg_fld == FLD_TMO)
            tmo_q <= cfg_wdata[TMO_W-1:0];
    end

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        localparam logic [ARB_W-1:0] ARB_RST = (i == 0) ? {ARB_W{1'b1}} : '0;
        logic              hit;
        logic [ARB_W-1:0]  arb_r;
        logic [DATA_W-1:0] vec_r;

        assign hit = cfg_we && (cfg_slot == SLOT_W'(i));

        // Arbitration number and vector of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                arb_r <= ARB_RST;
                vec_r <= '0;
            end else begin
                if (hit && cfg_fld == FLD_ARB) arb_r <= cfg_wdata[ARB_W-1:0];
                if (hit && cfg_fld == FLD_VEC) vec_r <= cfg_wdata;
            end
        end

        assign arb_q[i] = arb_r;
        assign vec_q[i] = vec_r;

        if (i == 0) begin : g_si
            // Slot 0 level is supplied by the external request input.
            assign lvl_q[i] = '0;
        end else begin : g_int
            logic [LVL_W-1:0] lvl_r;

            // Request level of an internal slot.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lvl_r <= '0;
                else if (hit && cfg_fld == FLD_LVL)
                    lvl_r <= cfg_wdata[LVL_W-1:0];
            end

            assign lvl_q[i] = lvl_r;
        end
    end

    AST_SI_ARB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_slot == '0 && cfg_fld == FLD_ARB) |=> $stable(arb_q[0])); // R12

endmodule

// File: rtl/iack_contend.sv
// Module: combinational contention among slots for the acknowledged priority.
// A slot contends when its level is nonzero and equals the presented
// priority. The largest arbitration number wins, and equal numbers go to the
// lowest slot index.
// Assumes: clk and rst_n are used only by the checks.
module iack_contend #(
    parameter int N_SLOTS = 8,
    parameter int ARB_W   = 4,
    parameter int LVL_W   = 3,
    localparam int SLOT_W = $clog2(N_SLOTS),
    localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LVL_W-1:0]              iack_lvl,
    input  logic [N_SLOTS-1:0][LVL_W-1:0] lvl,
    input  logic [N_SLOTS-1:0][ARB_W-1:0] arb,
    output logic                          found,
    output logic [SLOT_W-1:0]             win_idx,
    output logic [ARB_W-1:0]              win_arb,
    output logic                          tie
);

    logic [N_SLOTS-1:0] contend;
    logic [CNT_W-1:0]   n_same;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_match
        assign contend[i] = (lvl[i] != '0) && (lvl[i] == iack_lvl);
    end

    // Pick the contender with the largest number; strict compare keeps the
    // lowest index on equal numbers.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_arb = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (contend[i] && (!found || arb[i] > win_arb)) begin
                found   = 1'b1;
                win_idx = SLOT_W'(i);
                win_arb = arb[i];
            end
        end
    end

    // Count contenders sharing the winning number to detect a duplicate.
    always_comb begin
        n_same = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (contend[i] && arb[i] == win_arb)
                n_same = n_same + 1'b1;
        end
        tie = found && (win_arb != '0) && (n_same > CNT_W'(1));
    end

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_chk
        AST_WIN_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            contend[i] |-> (found && arb[i] <= win_arb)); // R3
        AST_TIE_LOW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
            !(contend[i] && arb[i] == win_arb && SLOT_W'(i) < win_idx)); // R6
    end

endmodule

// File: rtl/iack_seq.sv
// Module: acknowledge sequencer. It turns the contention result into a
// vector, a bus error, or an external-bus acknowledge with a bounded wait.
// Assumes: iack_start is a one-cycle pulse. A start while waiting is dropped.
module iack_seq
    import iack_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int ARB_W   = 4,
    parameter int LVL_W   = 3,
    parameter int DATA_W  = 8,
    parameter int TMO_W   = 8,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iack_start,
    input  logic [LVL_W-1:0]  iack_lvl,
    input  logic              found,
    input  logic [SLOT_W-1:0] win_idx,
    input  logic [ARB_W-1:0]  win_arb,
    input  logic [DATA_W-1:0] win_vec,
    input  logic              tie,
    input  logic [TMO_W-1:0]  tmo_q,
    input  logic              xbus_resp_valid,
    input  logic [DATA_W-1:0] xbus_resp_vec,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_vec,
    output logic              resp_berr,
    output logic              arb_conflict,
    output logic              xbus_ack_req,
    output logic [LVL_W-1:0]  xbus_ack_lvl
);

    seq_state_e       st;
    logic [TMO_W-1:0] cnt;
    logic [TMO_W-1:0] lim;
    logic             last_wait;

    // Effective limit: a programmed zero behaves as a single cycle.
    assign lim       = (tmo_q == '0) ? TMO_W'(1) : tmo_q;
    assign last_wait = (cnt == lim - 1'b1);

    // Sequencing state, wait counter and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= SEQ_IDLE;
            cnt          <= '0;
            resp_valid   <= 1'b0;
            resp_vec     <= '0;
            resp_berr    <= 1'b0;
            arb_conflict <= 1'b0;
            xbus_ack_lvl <= '0;
        end else begin
            resp_valid   <= 1'b0;
            resp_berr    <= 1'b0;
            arb_conflict <= 1'b0;
            unique case (st)
                SEQ_IDLE: begin
                    if (iack_start) begin
                        arb_conflict <= tie;
                        if (!found || win_arb == '0) begin
                            resp_berr <= 1'b1;
                        end else if (win_idx == '0) begin
                            st           <= SEQ_WAIT;
                            cnt          <= '0;
                            xbus_ack_lvl <= iack_lvl;
                        end else begin
                            resp_valid <= 1'b1;
                            resp_vec   <= win_vec;
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (xbus_resp_valid) begin
                        resp_valid <= 1'b1;
                        resp_vec   <= xbus_resp_vec;
                        st         <= SEQ_IDLE;
                    end else if (last_wait) begin
                        resp_berr <= 1'b1;
                        st        <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    assign xbus_ack_req = (st == SEQ_WAIT);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && resp_berr)); // R11
    AST_NOCONT_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_IDLE && iack_start && !found) |=> resp_berr); // R5
    AST_ZERO_ARB_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_IDLE && iack_start && found && win_arb == '0) |=> (resp_berr && !resp_valid)); // R4
    AST_XRESP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (xbus_ack_req && xbus_resp_valid) |=> (resp_valid && !xbus_ack_req)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_ack_req |-> (cnt < lim)); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (xbus_ack_req && !xbus_resp_valid && !last_wait) |=> (xbus_ack_req && $stable(xbus_ack_lvl))); // R10

endmodule

// File: rtl/iack_arbiter.sv
// Module: top of the interrupt acknowledge arbiter. It joins the register
// file, the contention logic and the acknowledge sequencer.
// Assumes: slot 0 represents external requests at level ext_req_lvl.
// Results appear one cycle after iack_start.
module iack_arbiter #(
    parameter int N_SLOTS = 8,
    parameter int ARB_W   = 4,
    parameter int LVL_W   = 3,
    parameter int DATA_W  = 8,
    parameter int TMO_W   = 8,
    parameter int TMO_RST = 16,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [1:0]        cfg_fld,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [LVL_W-1:0]  ext_req_lvl,
    input  logic              iack_start,
    input  logic [LVL_W-1:0]  iack_lvl,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_vec,
    output logic              resp_berr,
    output logic              arb_conflict,
    output logic              xbus_ack_req,
    output logic [LVL_W-1:0]  xbus_ack_lvl,
    input  logic              xbus_resp_valid,
    input  logic [DATA_W-1:0] xbus_resp_vec
);

    logic [N_SLOTS-1:0][ARB_W-1:0]  arb_q;
    logic [N_SLOTS-1:0][LVL_W-1:0]  lvl_q;
    logic [N_SLOTS-1:0][LVL_W-1:0]  lvl_eff;
    logic [N_SLOTS-1:0][DATA_W-1:0] vec_q;
    logic [TMO_W-1:0]               tmo_q;
    logic                           found;
    logic [SLOT_W-1:0]              win_idx;
    logic [ARB_W-1:0]               win_arb;
    logic                           tie;
    logic [DATA_W-1:0]              win_vec;

    iack_regs #(
        .N_SLOTS(N_SLOTS), .ARB_W(ARB_W), .LVL_W(LVL_W),
        .DATA_W(DATA_W), .TMO_W(TMO_W), .TMO_RST(TMO_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
        .arb_q(arb_q), .lvl_q(lvl_q), .vec_q(vec_q), .tmo_q(tmo_q)
    );

    // Slot 0 takes its level from the external request input.
    always_comb begin
        lvl_eff    = lvl_q;
        lvl_eff[0] = ext_req_lvl;
    end

    iack_contend #(
        .N_SLOTS(N_SLOTS), .ARB_W(ARB_W), .LVL_W(LVL_W)
    ) u_contend (
        .clk(clk), .rst_n(rst_n),
        .iack_lvl(iack_lvl), .lvl(lvl_eff), .arb(arb_q),
        .found(found), .win_idx(win_idx), .win_arb(win_arb), .tie(tie)
    );

    assign win_vec = vec_q[win_idx];

    iack_seq #(
        .N_SLOTS(N_SLOTS), .ARB_W(ARB_W), .LVL_W(LVL_W),
        .DATA_W(DATA_W), .TMO_W(TMO_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .iack_start(iack_start), .iack_lvl(iack_lvl),
        .found(found), .win_idx(win_idx), .win_arb(win_arb), .win_vec(win_vec),
        .tie(tie), .tmo_q(tmo_q),
        .xbus_resp_valid(xbus_resp_valid), .xbus_resp_vec(xbus_resp_vec),
        .resp_valid(resp_valid), .resp_vec(resp_vec), .resp_berr(resp_berr),
        .arb_conflict(arb_conflict),
        .xbus_ack_req(xbus_ack_req), .xbus_ack_lvl(xbus_ack_lvl)
    );

endmodule

// File: tb/iack_arbiter_bench.sv
// Bench: directed corner cases followed by seeded random acknowledge cycles.
// Expected outcomes come from a register model kept in the bench.
module iack_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_slot = '0;
    logic [1:0] cfg_fld = '0;
    logic [7:0] cfg_wdata = '0;
    logic [2:0] ext_req_lvl = '0;
    logic       iack_start = 1'b0;
    logic [2:0] iack_lvl = '0;
    logic       resp_valid, resp_berr, arb_conflict, xbus_ack_req;
    logic [7:0] resp_vec;
    logic [2:0] xbus_ack_lvl;
    logic       xbus_resp_valid = 1'b0;
    logic [7:0] xbus_resp_vec = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int m_arb[8];
    int m_lvl[8];
    int m_vec[8];
    int m_tmo;

    always #10 clk = ~clk;

    iack_arbiter u_iack_arbiter (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
        .ext_req_lvl(ext_req_lvl), .iack_start(iack_start), .iack_lvl(iack_lvl),
        .resp_valid(resp_valid), .resp_vec(resp_vec), .resp_berr(resp_berr),
        .arb_conflict(arb_conflict), .xbus_ack_req(xbus_ack_req), .xbus_ack_lvl(xbus_ack_lvl),
        .xbus_resp_valid(xbus_resp_valid), .xbus_resp_vec(xbus_resp_vec)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int slot, input int fld, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_fld = 2'(fld); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        case (fld)
            0: m_arb[slot] = data & 15;
            1: if (slot != 0) m_lvl[slot] = data & 7;
            2: m_vec[slot] = data & 255;
            default: m_tmo = data & 255;
        endcase
    endtask

    // Expected winner from the model: returns -1 when nobody contends.
    function automatic int exp_winner(input int lvl, output bit tie);
        int best = -1;
        int n_same = 0;
        for (int i = 0; i < 8; i++) begin
            int l = (i == 0) ? int'(ext_req_lvl) : m_lvl[i];
            if (l != 0 && l == lvl && (best < 0 || m_arb[i] > m_arb[best])) best = i;
        end
        if (best >= 0)
            for (int i = 0; i < 8; i++) begin
                int l = (i == 0) ? int'(ext_req_lvl) : m_lvl[i];
                if (l != 0 && l == lvl && m_arb[i] == m_arb[best]) n_same++;
            end
        tie = (best >= 0) && (m_arb[best] != 0) && (n_same > 1);
        return best;
    endfunction

    // One acknowledge cycle; delay < 0 means the external device never answers.
    task automatic do_iack(input int lvl, input int delay, input bit poke, input string req);
        bit tie;
        bit done = 0;
        int w = exp_winner(lvl, tie);
        int lim = (m_tmo == 0) ? 1 : m_tmo;
        int xv;
        @(negedge clk);
        iack_start = 1'b1; iack_lvl = 3'(lvl);
        @(negedge clk);
        iack_start = 1'b0;
        chk(arb_conflict == tie, "R6", {req, " conflict flag"}, int'(arb_conflict), int'(tie));
        if (w < 0 || m_arb[w] == 0) begin
            chk(resp_berr && !resp_valid && !xbus_ack_req, (w < 0) ? "R5" : "R4",
                {req, " spurious berr"}, int'(resp_berr), 1);
        end else if (w != 0) begin
            chk(resp_valid && !resp_berr && resp_vec == 8'(m_vec[w]), "R3",
                {req, " internal vector"}, int'(resp_vec), m_vec[w]);
        end else begin
            for (int k = 0; k < lim; k++) begin
                chk(xbus_ack_req && !resp_berr && !resp_valid && xbus_ack_lvl == 3'(lvl), "R7",
                    {req, " ext ack held"}, int'(xbus_ack_lvl), lvl);
                if (k == delay) begin
                    xv = int'($urandom_range(255));
                    xbus_resp_valid = 1'b1; xbus_resp_vec = 8'(xv);
                    @(negedge clk);
                    xbus_resp_valid = 1'b0;
                    chk(resp_valid && !resp_berr && !xbus_ack_req && resp_vec == 8'(xv), "R8",
                        {req, " ext vector"}, int'(resp_vec), xv);
                    done = 1;
                    break;
                end
                if (poke && k == 0) begin
                    iack_start = 1'b1; iack_lvl = 3'(lvl ^ 1);
                end
                @(negedge clk);
                iack_start = 1'b0;
            end
            if (!done)
                chk(resp_berr && !resp_valid && !xbus_ack_req, "R9",
                    {req, " timeout berr"}, int'(resp_berr), 1);
        end
        @(negedge clk);
        chk(!resp_valid && !resp_berr && !xbus_ack_req, "R11",
            {req, " single-cycle outcome"}, int'(resp_valid | resp_berr), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_arb[i] = (i == 0) ? 15 : 0; m_lvl[i] = 0; m_vec[i] = 0;
        end
        m_tmo = 16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!resp_valid && !resp_berr && !xbus_ack_req && !arb_conflict, "R1",
            "reset outputs", int'(resp_valid | resp_berr | xbus_ack_req), 0);

        // R1/R5: no internal requests after reset, so nobody contends.
        do_iack(3, -1, 0, "R1 empty");
        // R1/R9: slot 0 wins on its reset number; default 16-cycle timeout.
        ext_req_lvl = 3'd3;
        do_iack(3, -1, 0, "R1 default timeout");
        // R2: external request at a different level does not contend.
        do_iack(4, -1, 0, "R2 level mismatch");
        // R12: a level write to slot 0 is dropped.
        ext_req_lvl = 3'd0;
        cfg(0, 1, 5);
        do_iack(5, -1, 0, "R12 slot0 level dropped");
        // R3: internal winner by largest number.
        cfg(2, 1, 6); cfg(2, 0, 7); cfg(2, 2, 8'h42);
        cfg(5, 1, 6); cfg(5, 0, 9); cfg(5, 2, 8'h5A);
        do_iack(6, -1, 0, "R3 max wins");
        // R6: tie on 9 goes to slot 2.
        cfg(2, 0, 9);
        do_iack(6, -1, 0, "R6 tie low index");
        // R4: sole contender with number zero.
        cfg(3, 1, 2); cfg(3, 2, 8'h77);
        do_iack(2, -1, 0, "R4 zero number");
        // R8 and R10: external answer after 2 cycles, with an ignored start.
        ext_req_lvl = 3'd1;
        do_iack(1, 2, 1, "R10 start during wait");
        // R9: limit 0 acts as 1; limit 3.
        cfg(4, 3, 0);
        do_iack(1, -1, 0, "R9 zero limit");
        cfg(6, 3, 3);
        do_iack(1, -1, 0, "R9 limit 3");
        do_iack(1, 0, 0, "R8 immediate answer");

        // Random phase with small number range to provoke ties.
        for (int t = 0; t < 300; t++) begin
            int nw = int'($urandom_range(3));
            for (int j = 0; j < nw; j++) begin
                int s = int'($urandom_range(7));
                int f = int'($urandom_range(3));
                int d;
                case (f)
                    0: d = int'($urandom_range(3));
                    1: d = int'($urandom_range(7));
                    2: d = int'($urandom_range(255));
                    default: d = int'($urandom_range(6));
                endcase
                cfg(s, f, d);
            end
            ext_req_lvl = 3'($urandom_range(7));
            do_iack(int'($urandom_range(7)), int'($urandom_range(8)) - 1,
                    1'($urandom_range(1)), "random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule